// File: doc/BRIEF.md
# Tiled Address Bit-6 Swizzle Unit

This unit rewrites one bit of a byte address so that an agent writing a tiled surface places each 64-byte chunk on the same memory channel that the tiled reader expects. The memory configuration inputs describe how the memory is laid out. From them the unit works out one swizzle mode for X-tiled accesses and one for Y-tiled accesses. The request's tiling direction then picks one of the two modes. Address bit 6 is replaced by the XOR of bit 6 with the higher address bits that this mode names. Every other address bit passes through unchanged.

The unit is registered and takes one cycle. The output carries the translated address and the tiling that was actually applied. It also carries two mode codes. The physical mode is the code the hardware applies. The user-visible mode is the same code with the bit-17 term removed, because software cannot rely on bit 17 staying the same across paging. A configuration that cannot be read forces the unknown mode. A tiled request then falls back to linear with no swizzle.

Top module: `swz_unit`

## Requirements
- R1: A linear request (tile code 0, or the reserved code 3) is output with tile code 0, both mode codes 0 (NONE), and its address unchanged.
- R2: When the channel code is 0 (single channel), 1 (dual asymmetric) or 3 (reserved, treated as single), X-tiled (tile code 1) and Y-tiled (tile code 2) requests get mode code 0. Their tile code is kept and their address is unchanged.
- R3: Channel code 2 (dual interleaved) with the XOR-disable input high gives X mode code 2, where bit 6 becomes b6^b9^b10. It gives Y mode code 1, where bit 6 becomes b6^b9.
- R4: Channel code 2 with XOR-disable low and bit-17 select low gives X mode code 4 (b6^b9^b10^b11) and Y mode code 3 (b6^b9^b11).
- R5: Channel code 2 with XOR-disable low and bit-17 select high gives X mode code 6 (b6^b9^b10^b17) and Y mode code 5 (b6^b9^b17).
- R6: When the unreadable input is high, the derived mode is unknown (code 7), whatever the other configuration inputs are. A tiled request is then downgraded: the output tile code is 0, both mode codes are 0, and the address is unchanged. Code 7 never appears at the outputs.
- R7: The user-visible mode equals the physical mode, except that physical code 5 is reported as 1 and code 6 as 2.
- R8: out_valid equals in_valid one cycle earlier. While in_valid is low, out_addr, out_tile and both mode outputs keep their values. After reset, out_valid and all the other outputs are 0.
- R9: out_addr differs from the accepted input address in no bit other than bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| in_addr | input | AW (32) | Byte address of the request |
| in_tile | input | 2 | Tiling: 0 linear, 1 X, 2 Y, 3 treated as linear |
| cfg_chan | input | 2 | Channel layout: 0 single, 1 dual asymmetric, 2 dual interleaved, 3 treated as single |
| cfg_xor_off | input | 1 | Channel XOR randomisation disabled |
| cfg_sel17 | input | 1 | Randomisation uses bit 17 instead of bit 11 |
| cfg_unreadable | input | 1 | Configuration read returned all ones |
| out_valid | output | 1 | Registered result present |
| out_addr | output | AW (32) | Translated address |
| out_tile | output | 2 | Tiling actually applied |
| out_mode | output | 3 | User-visible mode code |
| out_phys_mode | output | 3 | Physical mode code |

## Verification
The hardest outcome to reach from the ports is a bit-17 mode that actually flips bit 6 through bit 17 alone. It needs the dual-interleaved layout, XOR enabled, bit-17 select high, a tiled request, and an address with bit 17 set while bits 9 to 11 cancel out. Uniform random stimulus seldom lines all of these up. Directed cases therefore set exactly this pattern for both tilings, and the random phase draws addresses whose upper bits vary independently. The unknown-configuration downgrade is driven both with readable-looking settings and with every tiling, so that the override is seen to take precedence.

// File: rtl/swz_pkg.sv
package swz_pkg;

  typedef enum logic [1:0] {
    TILE_LIN = 2'd0,
    TILE_X   = 2'd1,
    TILE_Y   = 2'd2,
    TILE_RSV = 2'd3
  } tile_e;

  typedef enum logic [1:0] {
    CH_SINGLE = 2'd0,
    CH_ASYM   = 2'd1,
    CH_INTLV  = 2'd2,
    CH_RSV    = 2'd3
  } chan_e;

  typedef enum logic [2:0] {
    SW_NONE     = 3'd0,
    SW_9        = 3'd1,
    SW_9_10     = 3'd2,
    SW_9_11     = 3'd3,
    SW_9_10_11  = 3'd4,
    SW_9_17     = 3'd5,
    SW_9_10_17  = 3'd6,
    SW_UNK      = 3'd7
  } swz_e;

  // Which address bits feed the XOR into bit 6
  typedef struct packed {
    logic t9;
    logic t10;
    logic t11;
    logic t17;
  } taps_t;

  localparam int unsigned SWZ_BIT  = 6;
  localparam int unsigned HI_TAP   = 17;

  function automatic taps_t mode_taps(swz_e m);
    taps_t t;
    t = '0;
    case (m)
      SW_9:       t.t9 = 1'b1;
      SW_9_10:    begin t.t9 = 1'b1; t.t10 = 1'b1; end
      SW_9_11:    begin t.t9 = 1'b1; t.t11 = 1'b1; end
      SW_9_10_11: begin t.t9 = 1'b1; t.t10 = 1'b1; t.t11 = 1'b1; end
      SW_9_17:    begin t.t9 = 1'b1; t.t17 = 1'b1; end
      SW_9_10_17: begin t.t9 = 1'b1; t.t10 = 1'b1; t.t17 = 1'b1; end
      default:    t = '0;
    endcase
    return t;
  endfunction

  // Remove the bit-17 term from a mode before software sees it
  function automatic swz_e hide_hi_tap(swz_e m);
    case (m)
      SW_9_17:    return SW_9;
      SW_9_10_17: return SW_9_10;
      default:    return m;
    endcase
  endfunction

endpackage

// File: rtl/swz_cfg_decode.sv
module swz_cfg_decode
  import swz_pkg::*;
(
  input  logic [1:0] chan_i,
  input  logic       xor_off_i,
  input  logic       sel17_i,
  input  logic       unreadable_i,
  output swz_e       x_mode_o,
  output swz_e       y_mode_o,
  output logic       cfg_unknown_o
);

  chan_e chan;
  logic  interleaved;

  assign chan          = chan_e'(chan_i);
  assign interleaved   = (chan == CH_INTLV);
  assign cfg_unknown_o = unreadable_i;

  always_comb begin
    x_mode_o = SW_NONE;
    y_mode_o = SW_NONE;
    if (unreadable_i) begin
      x_mode_o = SW_UNK;
      y_mode_o = SW_UNK;
    end else if (interleaved) begin
      if (xor_off_i) begin
        x_mode_o = SW_9_10;
        y_mode_o = SW_9;
      end else if (!sel17_i) begin
        x_mode_o = SW_9_10_11;
        y_mode_o = SW_9_11;
      end else begin
        x_mode_o = SW_9_10_17;
        y_mode_o = SW_9_17;
      end
    end
  end

endmodule

// File: rtl/swz_tile_select.sv
module swz_tile_select
  import swz_pkg::*;
(
  input  logic [1:0] tile_i,
  input  swz_e       x_mode_i,
  input  swz_e       y_mode_i,
  output swz_e       phys_mode_o,
  output swz_e       user_mode_o,
  output tile_e      eff_tile_o,
  output logic       downgrade_o
);

  tile_e tile;
  logic  is_tiled;
  swz_e  picked;

  assign tile     = tile_e'(tile_i);
  assign is_tiled = (tile == TILE_X) || (tile == TILE_Y);
  assign picked   = (tile == TILE_X) ? x_mode_i : y_mode_i;

  always_comb begin
    phys_mode_o = SW_NONE;
    eff_tile_o  = TILE_LIN;
    downgrade_o = 1'b0;
    if (is_tiled) begin
      if (picked == SW_UNK) begin
        downgrade_o = 1'b1;
      end else begin
        phys_mode_o = picked;
        eff_tile_o  = tile;
      end
    end
  end

  assign user_mode_o = hide_hi_tap(phys_mode_o);

endmodule

// File: rtl/swz_addr_xlate.sv
module swz_addr_xlate
  import swz_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] addr_i,
  input  swz_e          mode_i,
  output logic [AW-1:0] addr_o,
  output logic          flip_o
);

  taps_t taps;

  assign taps   = mode_taps(mode_i);
  assign flip_o = (taps.t9  & addr_i[9])
                ^ (taps.t10 & addr_i[10])
                ^ (taps.t11 & addr_i[11])
                ^ (taps.t17 & addr_i[HI_TAP]);

  always_comb begin
    addr_o          = addr_i;
    addr_o[SWZ_BIT] = addr_i[SWZ_BIT] ^ flip_o;
  end

endmodule

// File: rtl/swz_unit.sv
module swz_unit
  import swz_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [AW-1:0] in_addr,
  input  logic [1:0]    in_tile,
  input  logic [1:0]    cfg_chan,
  input  logic          cfg_xor_off,
  input  logic          cfg_sel17,
  input  logic          cfg_unreadable,
  output logic          out_valid,
  output logic [AW-1:0] out_addr,
  output logic [1:0]    out_tile,
  output logic [2:0]    out_mode,
  output logic [2:0]    out_phys_mode
);

  localparam logic [AW-1:0] KEEP_MASK = ~(AW'(1) << SWZ_BIT);

  swz_e          x_mode, y_mode, phys_mode, user_mode;
  tile_e         eff_tile;
  logic          cfg_unknown, downgrade, bit6_flip;
  logic [AW-1:0] xl_addr;

  swz_cfg_decode u_cfg (
    .chan_i        (cfg_chan),
    .xor_off_i     (cfg_xor_off),
    .sel17_i       (cfg_sel17),
    .unreadable_i  (cfg_unreadable),
    .x_mode_o      (x_mode),
    .y_mode_o      (y_mode),
    .cfg_unknown_o (cfg_unknown)
  );

  swz_tile_select u_sel (
    .tile_i      (in_tile),
    .x_mode_i    (x_mode),
    .y_mode_i    (y_mode),
    .phys_mode_o (phys_mode),
    .user_mode_o (user_mode),
    .eff_tile_o  (eff_tile),
    .downgrade_o (downgrade)
  );

  swz_addr_xlate #(.AW(AW)) u_xl (
    .addr_i (in_addr),
    .mode_i (phys_mode),
    .addr_o (xl_addr),
    .flip_o (bit6_flip)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_addr      <= '0;
      out_tile      <= '0;
      out_mode      <= '0;
      out_phys_mode <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_addr      <= xl_addr;
        out_tile      <= eff_tile;
        out_mode      <= user_mode;
        out_phys_mode <= phys_mode;
      end
    end
  end

  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  // R8
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> ($stable(out_addr) && $stable(out_phys_mode) && $stable(out_tile)));

  // R9
  only_bit6_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (((out_addr ^ $past(in_addr)) & KEEP_MASK) == '0));

  // R1
  linear_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_tile == 2'd0) |-> (out_addr == $past(in_addr) && out_phys_mode == 3'd0));

  // R6
  unknown_downgrade_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(cfg_unknown)) |-> (out_tile == 2'd0 && out_mode == 3'd0 && out_phys_mode == 3'd0));

  // R7
  user_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_mode != 3'd5 && out_mode != 3'd6 && out_phys_mode != 3'd7));

  // R6
  downgrade_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    downgrade |-> (cfg_unknown && !bit6_flip));

endmodule

// File: tb/swz_unit_bench.sv
module swz_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int SEED = 1234;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [AW-1:0] in_addr = '0;
  logic [1:0]    in_tile = '0;
  logic [1:0]    cfg_chan = '0;
  logic          cfg_xor_off = 1'b0;
  logic          cfg_sel17 = 1'b0;
  logic          cfg_unreadable = 1'b0;
  logic          out_valid;
  logic [AW-1:0] out_addr;
  logic [1:0]    out_tile;
  logic [2:0]    out_mode;
  logic [2:0]    out_phys_mode;

  int checks = 0;
  int errors = 0;
  logic finished = 1'b0;

  logic [AW-1:0] last_addr = '0;
  logic [1:0]    last_tile = '0;
  logic [2:0]    last_user = '0;
  logic [2:0]    last_phys = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  swz_unit #(.AW(AW)) u_swz_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
    .in_tile(in_tile), .cfg_chan(cfg_chan), .cfg_xor_off(cfg_xor_off),
    .cfg_sel17(cfg_sel17), .cfg_unreadable(cfg_unreadable),
    .out_valid(out_valid), .out_addr(out_addr), .out_tile(out_tile),
    .out_mode(out_mode), .out_phys_mode(out_phys_mode)
  );

  function automatic logic [2:0] exp_phys(logic [1:0] t, logic [1:0] ch,
                                          logic xo, logic s17, logic unr);
    logic [2:0] xm, ym;
    if (t == 2'd0 || t == 2'd3) return 3'd0;
    if (unr) return 3'd0;
    if (ch != 2'd2) return 3'd0;
    if (xo)        begin xm = 3'd2; ym = 3'd1; end
    else if (!s17) begin xm = 3'd4; ym = 3'd3; end
    else           begin xm = 3'd6; ym = 3'd5; end
    return (t == 2'd1) ? xm : ym;
  endfunction

  function automatic logic [1:0] exp_tile(logic [1:0] t, logic unr);
    return ((t == 2'd1 || t == 2'd2) && !unr) ? t : 2'd0;
  endfunction

  function automatic logic [2:0] exp_user(logic [2:0] p);
    if (p == 3'd5) return 3'd1;
    if (p == 3'd6) return 3'd2;
    return p;
  endfunction

  function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] a, logic [2:0] p);
    logic x;
    case (p)
      3'd1: x = a[9];
      3'd2: x = a[9] ^ a[10];
      3'd3: x = a[9] ^ a[11];
      3'd4: x = a[9] ^ a[10] ^ a[11];
      3'd5: x = a[9] ^ a[17];
      3'd6: x = a[9] ^ a[10] ^ a[17];
      default: x = 1'b0;
    endcase
    return a ^ ({{(AW-1){1'b0}}, x} << 6);
  endfunction

  function automatic string req_tag(logic [1:0] t, logic [1:0] ch,
                                    logic xo, logic s17, logic unr);
    if (t == 2'd0 || t == 2'd3) return "R1";
    if (unr) return "R6";
    if (ch != 2'd2) return "R2";
    if (xo) return "R3";
    if (!s17) return "R4";
    return "R5";
  endfunction

  task automatic chk(string tag, string what, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic send(logic [AW-1:0] a, logic [1:0] t, logic [1:0] ch,
                      logic xo, logic s17, logic unr);
    logic [2:0] p;
    string tag;
    in_valid = 1'b1; in_addr = a; in_tile = t; cfg_chan = ch;
    cfg_xor_off = xo; cfg_sel17 = s17; cfg_unreadable = unr;
    @(negedge clk);
    p   = exp_phys(t, ch, xo, s17, unr);
    tag = req_tag(t, ch, xo, s17, unr);
    chk("R8", "valid", AW'(out_valid), AW'(1));
    chk(tag, "addr", out_addr, exp_addr(a, p));
    chk(tag, "tile", AW'(out_tile), AW'(exp_tile(t, unr)));
    chk(tag, "phys_mode", AW'(out_phys_mode), AW'(p));
    chk((p == 3'd5 || p == 3'd6) ? "R7" : tag, "user_mode", AW'(out_mode), AW'(exp_user(p)));
    // R9: nothing outside bit 6 moves
    chk("R9", "upper_bits", (out_addr ^ a) & ~(AW'(1) << 6), '0);
    last_addr = exp_addr(a, p); last_tile = exp_tile(t, unr);
    last_user = exp_user(p);    last_phys = p;
  endtask

  task automatic idle(logic [AW-1:0] a, logic [1:0] t);
    in_valid = 1'b0; in_addr = a; in_tile = t;
    cfg_chan = 2'd2; cfg_xor_off = 1'b0; cfg_sel17 = 1'b1; cfg_unreadable = 1'b0;
    @(negedge clk);
    chk("R8", "idle_valid", AW'(out_valid), '0);
    chk("R8", "idle_addr", out_addr, last_addr);
    chk("R8", "idle_tile", AW'(out_tile), AW'(last_tile));
    chk("R8", "idle_mode", AW'(out_mode), AW'(last_user));
    chk("R8", "idle_phys", AW'(out_phys_mode), AW'(last_phys));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(SEED);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk("R8", "reset_valid", AW'(out_valid), '0);
    chk("R8", "reset_addr", out_addr, '0);
    chk("R8", "reset_modes", AW'({out_tile, out_mode, out_phys_mode}), '0);

    // Directed corners
    send(32'h0000_0640, 2'd0, 2'd2, 1'b0, 1'b1, 1'b0); // R1 linear
    send(32'h0000_0640, 2'd3, 2'd2, 1'b0, 1'b0, 1'b0); // R1 reserved tile
    send(32'h0000_0200, 2'd1, 2'd0, 1'b0, 1'b0, 1'b0); // R2 single
    send(32'h0000_0200, 2'd2, 2'd1, 1'b0, 1'b1, 1'b0); // R2 asym
    send(32'h0000_0400, 2'd1, 2'd2, 1'b1, 1'b0, 1'b0); // R3 X via bit 10
    send(32'h0000_0400, 2'd2, 2'd2, 1'b1, 1'b0, 1'b0); // R3 Y ignores bit 10
    send(32'h0000_0800, 2'd1, 2'd2, 1'b0, 1'b0, 1'b0); // R4 X via bit 11
    send(32'h0000_0A00, 2'd2, 2'd2, 1'b0, 1'b0, 1'b0); // R4 Y bits 9,11 cancel
    send(32'h0002_0000, 2'd1, 2'd2, 1'b0, 1'b1, 1'b0); // R5 X via bit 17 alone
    send(32'h0002_0040, 2'd2, 2'd2, 1'b0, 1'b1, 1'b0); // R5/R7 Y via bit 17
    send(32'h0002_0600, 2'd1, 2'd2, 1'b0, 1'b1, 1'b0); // R5 bits 9,10 cancel, 17 flips
    send(32'h0002_0E40, 2'd1, 2'd2, 1'b0, 1'b1, 1'b1); // R6 downgrade X
    send(32'h0002_0E40, 2'd2, 2'd2, 1'b1, 1'b0, 1'b1); // R6 downgrade Y
    send(32'h0002_0E40, 2'd2, 2'd0, 1'b0, 1'b0, 1'b1); // R6 single+unreadable
    idle(32'hFFFF_FFFF, 2'd1);                         // R8 hold
    idle(32'h1234_5678, 2'd2);

    // Constrained random
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 7) == 0)
        idle($urandom, 2'($urandom_range(0, 3)));
      else
        send($urandom, 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
             1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
             1'($urandom_range(0, 9) == 0));
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule